// File: doc/BRIEF.md
# Paged Change-Interrupt Controller for a 24-Line Input Group

This block watches 24 input pins arranged as three 8-bit ports and raises a single interrupt request when a pin shows the edge that software selected for it. Each pin is brought into the clock domain by a two-stage synchronizer. A third register holds the previous level, and the edge detector compares against it. Per pin, software chooses a rising or a falling edge and sets an enable. Each pin has a pending flag that latches the selected edge while the pin is enabled.

Software reaches the block through an 8-bit register window. A bank-select register at offset 7 chooses which bank appears at offsets 8 to 10: polarity, enable or pending identification. In page 0, offsets 0 to 2 show the synchronized pin levels. Offset 6 is always a summary with one bit per port. To acknowledge a pending pin, software writes its enable bit to 0 and then writes it back to 1. There is no separate write-one-to-clear register. The interrupt request is high whenever any port summary bit is set.

Top module: `pgdio_irq_ctl`

## Requirements
- R1: After reset, every register is zero and the interrupt request is low. This covers the page selection (page 0), the polarity registers, the enable registers and the pending flags.
- R2: A write to offset 7 loads the page from data bits 7:6: 0 is the level page, 1 is polarity, 2 is enable and 3 is identification. A read of offset 7 returns the page in bits 7:6 and zero in bits 5:0.
- R3: In page 0, a read of offset p (p = 0, 1, 2) returns the synchronized levels of port p. Software line n (1 to 24) is port (n-1)/8, bit (n-1)%8.
- R4: In page 1, offsets 8, 9 and 10 are read/write polarity registers for ports 0, 1 and 2. A bit value of 1 selects the rising edge and 0 selects the falling edge.
- R5: In page 2, offsets 8, 9 and 10 are read/write enable registers for ports 0, 1 and 2.
- R6: A pending flag sets only when its enable bit is 1 and the selected edge is seen. The opposite edge does not set it, and neither does any edge on a disabled pin.
- R7: In page 3, offsets 8, 9 and 10 return the pending flags of ports 0, 1 and 2. Writes to these offsets in page 3 change nothing.
- R8: A read of offset 6 returns, in bit p, the OR of the pending flags of port p. Bits 7:3 read as zero. The read is the same in every page.
- R9: The interrupt request equals the OR of the three summary bits.
- R10: Writing 0 to an enable bit clears that pin's pending flag. Writing 1 afterwards re-arms the pin without setting its flag. Pending flags of other pins are unaffected.
- R11: If a selected edge and a write of 0 to the same enable bit fall in the same cycle, the flag ends up clear.
- R12: Suppose a pin level is sampled at clock edge k. The level registers show it after edge k+1, and a resulting pending flag appears after edge k+2.
- R13: Some offsets are page-dependent and are accessed in a page that does not map them: offsets 0 to 2 outside page 0, and offsets 8 to 10 in page 0. These read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_rd | input | 1 | Read strobe; read data is combinational while high |
| bus_wr | input | 1 | Write strobe, taken at the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when bus_rd is low |
| pins_i | input | 24 | Monitored input pins, line 1 at bit 0 |
| irq_o | output | 1 | Interrupt request |

## Verification
Some internal faults show up at the ports within a few cycles:
- A wrong page register makes the next read of offsets 8 to 10 return the wrong bank at once.
- A wrong polarity or enable bit shows up as a pending flag that is missing or spurious. This appears in the identification bank, the summary and the interrupt request three clock edges after the pin changes.
- A pending flag that survives the enable toggle leaves the interrupt request high on the very next cycle.

The bench exercises the same-cycle race between an edge and a clear. It also makes wrong-edge and disabled-pin stimuli visible through the identification bank before it moves on.

// File: rtl/pgdio_pkg.sv
package pgdio_pkg;

    localparam int PORT_W    = 8;
    localparam int NUM_PORTS = 3;
    localparam int ADDR_W    = 4;

    localparam int OFS_MASTER = 6;
    localparam int OFS_PAGE   = 7;
    localparam int OFS_BANK   = 8;

    typedef enum logic [1:0] {
        PG_LEVEL    = 2'd0,
        PG_POLARITY = 2'd1,
        PG_ENABLE   = 2'd2,
        PG_IDENT    = 2'd3
    } page_e;

    typedef struct packed {
        logic [PORT_W-1:0] pol;
        logic [PORT_W-1:0] en;
        logic [PORT_W-1:0] pend;
    } port_regs_t;

    function automatic logic [PORT_W-1:0] edge_select(
        input logic [PORT_W-1:0] rise,
        input logic [PORT_W-1:0] fall,
        input logic [PORT_W-1:0] pol
    );
        return (pol & rise) | (~pol & fall);
    endfunction

endpackage

// File: rtl/pgdio_sync.sv
module pgdio_sync #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    // Per pin: two synchronizer stages plus one history stage
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [2:0] stg;

        always_ff @(posedge clk) begin
            if (rst) stg <= '0;
            else     stg <= {stg[1:0], pin_i[b]};
        end

        assign level_o[b] = stg[1];
        assign rise_o[b]  = stg[1] & ~stg[2];
        assign fall_o[b]  = ~stg[1] & stg[2];
    end

endmodule

// File: rtl/pgdio_port.sv
module pgdio_port
    import pgdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pol_we,
    input  logic              en_we,
    input  logic [PORT_W-1:0] wdata,
    input  logic [PORT_W-1:0] rise_i,
    input  logic [PORT_W-1:0] fall_i,
    output port_regs_t        regs_o
);

    port_regs_t        r;
    logic [PORT_W-1:0] edge_v;
    logic [PORT_W-1:0] clr_v;
    logic [PORT_W-1:0] set_v;
    logic [PORT_W-1:0] pend_n;

    always_comb begin
        edge_v = edge_select(rise_i, fall_i, r.pol);
        set_v  = edge_v & r.en;
        clr_v  = en_we ? ~wdata : '0;
        pend_n = (r.pend | set_v) & ~clr_v;   // clear dominates a same-cycle set
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r <= '0;
        end else begin
            if (pol_we) r.pol <= wdata;
            if (en_we)  r.en  <= wdata;
            r.pend <= pend_n;
        end
    end

    assign regs_o = r;

    AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (r.pend & ~r.en) == '0);   // R10

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        en_we |=> ((r.pend & ~$past(wdata)) == '0));   // R11

    AST_SET_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((r.pend & ~$past(r.pend) & ~$past(edge_v & r.en)) == '0));   // R6

endmodule

// File: rtl/pgdio_regif.sv
module pgdio_regif
    import pgdio_pkg::*;
#(
    parameter int NPORT = NUM_PORTS
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic                         rd_i,
    input  logic                         wr_i,
    input  logic [PORT_W-1:0]            wdata_i,
    input  logic [NPORT-1:0][PORT_W-1:0] level_i,
    input  port_regs_t [NPORT-1:0]       regs_i,
    output logic [NPORT-1:0]             pol_we_o,
    output logic [NPORT-1:0]             en_we_o,
    output logic [NPORT-1:0]             master_o,
    output logic [PORT_W-1:0]            rdata_o
);

    localparam int PAGE_LSB = PORT_W - 2;

    page_e page_q;
    logic  page_wr;

    assign page_wr = wr_i && (addr_i == ADDR_W'(OFS_PAGE));

    always_ff @(posedge clk) begin
        if (rst)          page_q <= PG_LEVEL;
        else if (page_wr) page_q <= page_e'(wdata_i[PORT_W-1:PAGE_LSB]);
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_dec
        logic bank_hit;
        assign bank_hit    = (addr_i == ADDR_W'(OFS_BANK + p));
        assign pol_we_o[p] = wr_i && bank_hit && (page_q == PG_POLARITY);
        assign en_we_o[p]  = wr_i && bank_hit && (page_q == PG_ENABLE);
        assign master_o[p] = |regs_i[p].pend;
    end

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            if (addr_i == ADDR_W'(OFS_PAGE)) begin
                rdata_o[PORT_W-1:PAGE_LSB] = page_q;
            end else if (addr_i == ADDR_W'(OFS_MASTER)) begin
                rdata_o = PORT_W'(master_o);
            end else begin
                for (int p = 0; p < NPORT; p++) begin
                    if (page_q == PG_LEVEL && addr_i == ADDR_W'(p))
                        rdata_o = level_i[p];
                    if (addr_i == ADDR_W'(OFS_BANK + p)) begin
                        case (page_q)
                            PG_POLARITY: rdata_o = regs_i[p].pol;
                            PG_ENABLE:   rdata_o = regs_i[p].en;
                            PG_IDENT:    rdata_o = regs_i[p].pend;
                            default:     rdata_o = '0;
                        endcase
                    end
                end
            end
        end
    end

    AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (rst)
        page_wr |=> (page_q == $past(wdata_i[PORT_W-1:PAGE_LSB])));   // R2

    always_comb begin
        if (!rst && rd_i && addr_i == ADDR_W'(OFS_MASTER))
            AST_MASTER_UPPER_ZERO: assert (rdata_o[PORT_W-1:NPORT] == '0);   // R8
    end

endmodule

// File: rtl/pgdio_irq_ctl.sv
module pgdio_irq_ctl
    import pgdio_pkg::*;
#(
    parameter int NPORT = NUM_PORTS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_rd,
    input  logic                    bus_wr,
    input  logic [PORT_W-1:0]       bus_wdata,
    output logic [PORT_W-1:0]       bus_rdata,
    input  logic [NPORT*PORT_W-1:0] pins_i,
    output logic                    irq_o
);

    localparam int NPIN = NPORT * PORT_W;

    logic [NPIN-1:0]              level_w;
    logic [NPIN-1:0]              rise_w;
    logic [NPIN-1:0]              fall_w;
    logic [NPORT-1:0][PORT_W-1:0] level_pp;
    port_regs_t [NPORT-1:0]       regs_w;
    logic [NPORT-1:0]             pol_we;
    logic [NPORT-1:0]             en_we;
    logic [NPORT-1:0]             master;
    logic [NPORT-1:0]             en_any;

    pgdio_sync #(.W(NPIN)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pin_i   (pins_i),
        .level_o (level_w),
        .rise_o  (rise_w),
        .fall_o  (fall_w)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign level_pp[p] = level_w[p*PORT_W +: PORT_W];
        assign en_any[p]   = |regs_w[p].en;

        pgdio_port u_port (
            .clk    (clk),
            .rst    (rst),
            .pol_we (pol_we[p]),
            .en_we  (en_we[p]),
            .wdata  (bus_wdata),
            .rise_i (rise_w[p*PORT_W +: PORT_W]),
            .fall_i (fall_w[p*PORT_W +: PORT_W]),
            .regs_o (regs_w[p])
        );
    end

    pgdio_regif #(.NPORT(NPORT)) u_regif (
        .clk      (clk),
        .rst      (rst),
        .addr_i   (bus_addr),
        .rd_i     (bus_rd),
        .wr_i     (bus_wr),
        .wdata_i  (bus_wdata),
        .level_i  (level_pp),
        .regs_i   (regs_w),
        .pol_we_o (pol_we),
        .en_we_o  (en_we),
        .master_o (master),
        .rdata_o  (bus_rdata)
    );

    assign irq_o = |master;

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (en_any == '0) |-> !irq_o);   // R9

endmodule

// File: tb/pgdio_irq_ctl_test.sv
`timescale 1ns/100ps
module pgdio_irq_ctl_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  bus_addr;
    logic        bus_rd;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic [23:0] pins;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pgdio_irq_ctl uut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pins_i    (pins),
        .irq_o     (irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    // Called just after a falling edge; commits at the next rising edge
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
        bus_addr = a; bus_rd = 1'b1;
        #0.2;
        chk(req, bus_rdata, exp);
        bus_rd = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset;
        rst = 1'b1; pins = '0; bus_rd = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
        wait_cyc(3);
        rst = 1'b0;
    endtask

    task automatic t_reset;
        do_reset();
        rd_chk("R1 page", 4'd7, 8'h00);
        rd_chk("R1 summary", 4'd6, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        wr(4'd7, 8'h40);
        for (int p = 0; p < 3; p++) rd_chk("R1 polarity", 4'(8 + p), 8'h00);
        wr(4'd7, 8'h80);
        for (int p = 0; p < 3; p++) rd_chk("R1 enable", 4'(8 + p), 8'h00);
        wr(4'd7, 8'hC0);
        for (int p = 0; p < 3; p++) rd_chk("R1 pending", 4'(8 + p), 8'h00);
    endtask

    task automatic t_page;
        do_reset();
        wr(4'd7, 8'hC0);
        rd_chk("R2 page 3", 4'd7, 8'hC0);
        wr(4'd7, 8'h7F);
        rd_chk("R2 low bits dropped", 4'd7, 8'h40);
    endtask

    task automatic t_levels;
        do_reset();
        pins = 24'h5AC381;
        wait_cyc(1);
        rd_chk("R12 level not yet", 4'd0, 8'h00);
        wait_cyc(1);
        rd_chk("R3 port0", 4'd0, 8'h81);
        rd_chk("R3 port1", 4'd1, 8'hC3);
        rd_chk("R3 port2", 4'd2, 8'h5A);
        wr(4'd7, 8'h80);
        rd_chk("R13 level outside page 0", 4'd0, 8'h00);
    endtask

    task automatic t_pol_en;
        do_reset();
        wr(4'd7, 8'h40);
        wr(4'd8, 8'h12); wr(4'd9, 8'h34); wr(4'd10, 8'h56);
        rd_chk("R4 pol port0", 4'd8, 8'h12);
        rd_chk("R4 pol port1", 4'd9, 8'h34);
        rd_chk("R4 pol port2", 4'd10, 8'h56);
        wr(4'd7, 8'h80);
        wr(4'd8, 8'hF0); wr(4'd9, 8'h0F); wr(4'd10, 8'hAA);
        rd_chk("R5 en port0", 4'd8, 8'hF0);
        rd_chk("R5 en port1", 4'd9, 8'h0F);
        rd_chk("R5 en port2", 4'd10, 8'hAA);
        wr(4'd7, 8'h00);
        rd_chk("R13 bank read in page 0", 4'd9, 8'h00);
        wr(4'd9, 8'hFF);
        wr(4'd7, 8'h40);
        rd_chk("R13 page 0 write ignored (pol)", 4'd9, 8'h34);
        wr(4'd7, 8'h80);
        rd_chk("R13 page 0 write ignored (en)", 4'd9, 8'h0F);
    endtask

    task automatic t_edges;
        do_reset();
        wr(4'd7, 8'h40); wr(4'd8, 8'h08);       // bit3 rising, rest falling
        wr(4'd7, 8'h80); wr(4'd8, 8'h0C);       // bits 2,3 enabled
        wr(4'd7, 8'hC0);
        pins[3] = 1'b1;                          // line 4
        wait_cyc(2);
        rd_chk("R12 pending not yet", 4'd8, 8'h00);
        chk("R12 irq not yet", {7'd0, irq}, 8'h00);
        wait_cyc(1);
        rd_chk("R6 rising edge sets", 4'd8, 8'h08);
        rd_chk("R8 summary port0", 4'd6, 8'h01);
        chk("R9 irq high", {7'd0, irq}, 8'h01);
        pins[2] = 1'b1;
        wait_cyc(3);
        rd_chk("R6 wrong edge ignored", 4'd8, 8'h08);
        pins[2] = 1'b0;
        wait_cyc(3);
        rd_chk("R6 falling edge sets", 4'd8, 8'h0C);
        pins[5] = 1'b1; wait_cyc(3);
        pins[5] = 1'b0; wait_cyc(3);
        rd_chk("R6 disabled pin ignored", 4'd8, 8'h0C);
    endtask

    task automatic t_ident_ro;
        do_reset();
        wr(4'd7, 8'h40); wr(4'd9, 8'h01);
        wr(4'd7, 8'h80); wr(4'd9, 8'h01);
        pins[8] = 1'b1;                          // line 9
        wait_cyc(3);
        wr(4'd7, 8'hC0);
        wr(4'd9, 8'h00);
        rd_chk("R7 ident write ignored", 4'd9, 8'h01);
        rd_chk("R8 summary port1", 4'd6, 8'h02);
        wr(4'd7, 8'h80);
        rd_chk("R7 enable untouched", 4'd9, 8'h01);
    endtask

    task automatic t_clear;
        do_reset();
        wr(4'd7, 8'h40); wr(4'd9, 8'h01); wr(4'd10, 8'h80);
        wr(4'd7, 8'h80); wr(4'd9, 8'h01); wr(4'd10, 8'h80);
        pins[8] = 1'b1; pins[23] = 1'b1;
        wait_cyc(3);
        rd_chk("R8 summary two ports", 4'd6, 8'h06);
        wr(4'd10, 8'h00); wr(4'd10, 8'h80);
        wr(4'd7, 8'hC0);
        rd_chk("R10 toggled pin cleared", 4'd10, 8'h00);
        rd_chk("R10 other pin kept", 4'd9, 8'h01);
        rd_chk("R8 summary after clear", 4'd6, 8'h02);
        chk("R9 irq still high", {7'd0, irq}, 8'h01);
        wr(4'd7, 8'h80);
        wr(4'd9, 8'h00); wr(4'd9, 8'h01);
        rd_chk("R10 re-armed enable", 4'd9, 8'h01);
        rd_chk("R8 summary empty", 4'd6, 8'h00);
        chk("R9 irq low", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_clear_wins;
        do_reset();
        wr(4'd7, 8'h40); wr(4'd8, 8'h01);
        wr(4'd7, 8'h80); wr(4'd8, 8'h01);
        pins[0] = 1'b1;                          // sampled at edge k
        wait_cyc(2);                             // now between k+1 and k+2
        wr(4'd8, 8'h00);                         // commits at k+2, same as the set
        wr(4'd8, 8'h01);
        wr(4'd7, 8'hC0);
        rd_chk("R11 clear beats edge", 4'd8, 8'h00);
        chk("R11 irq low", {7'd0, irq}, 8'h00);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_page();
        t_levels();
        t_pol_en();
        t_edges();
        t_ident_ro();
        t_clear();
        t_clear_wins();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule